// File: doc/BRIEF.md
# Protected Clock Configuration Register Bank

This block holds the software-visible clock settings of a chip. It contains four clock control registers, a peripheral clock divider select, and a mode register that carries one-way lock bits. Software reaches all of them through a plain register bus made of an address, write data, a write strobe and combinational read data. Writes to the sensitive registers only land while the matching write-enable bit in a guard register is open.

The mode register has three sticky bits. Software can set each of them, but only a reset clears them. The clock lock freezes selected fields of the clock and PLL registers. The watchdog lock moves the watchdog onto the on-chip oscillator, keeps that oscillator running, and stops software from requesting stop mode. The NMI bit hands the shared pin to the NMI function for good.

The block also drives the current register values out to the clock generator. From them it derives the SFR access wait count, the watchdog source select and the pin function.

Top module: `clkcfg_bank`

## Requirements
- R1: After reset, every register reads 0 except the mode register (address 6), which reads 0x03.
- R2: Writes to addresses 1 to 5 take effect only while guard bit 0 is 1. Writes to the mode register take effect only while guard bit 1 is 1. A blocked write changes nothing.
- R3: Guard register (address 0) bits 1:0 are plain read/write bits that keep their value until written again.
- R4: Mode bit 2 (clock lock) is set by writing 1. No later write clears it; only reset does. `clk_locked_o` shows its value.
- R5: While the clock lock is set, the following bits keep their values on every write: address 1 bits 7, 5 and 2; address 2 bits 1:0; address 3 bit 0; all bits of address 4. All other bits of those registers remain writable.
- R6: Mode bit 3 (watchdog lock) is sticky in the same way. While it is set, `wdt_src_onchip_o` is 1 and `onchip_osc_run_o` is 1. Otherwise `onchip_osc_run_o` follows address 3 bit 1.
- R7: While the watchdog lock is set and the clock lock is not, a write of 1 to address 2 bit 0 (stop request) does not set that bit. A write of 0 still clears it.
- R8: Mode bit 4 (NMI pin function) is sticky in the same way, and `nmi_pin_o` shows its value.
- R9: `sfr_wait_o` is 1 only when address 4 bit 7 (PLL on) and mode bit 0 are both 1. In every other case it is 2.
- R10: These bits ignore writes and read as 0: address 5 bits 7:2, mode bits 7:5, guard bits 7:2, and all of address 7.
- R11: Reads return the current register contents whatever the guard state, and the register outputs equal the read values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr |
| ctl0_o | output | 8 | Clock control register 0 (address 1) |
| ctl1_o | output | 8 | Clock control register 1 (address 2), bit 0 is the stop request |
| ctl2_o | output | 8 | Clock control register 2 (address 3) |
| pll_o | output | 8 | PLL control register (address 4), bit 7 is PLL on |
| psel_o | output | 2 | Peripheral clock select (address 5) |
| sfr_wait_o | output | 2 | SFR access wait states (1 or 2) |
| wdt_src_onchip_o | output | 1 | Watchdog counts the on-chip oscillator |
| onchip_osc_run_o | output | 1 | On-chip oscillator enabled |
| nmi_pin_o | output | 1 | Shared pin acts as NMI |
| clk_locked_o | output | 1 | Clock lock state |

## Verification
The bench goes after four kinds of corner case.

- **Sticky bits.** It tries to clear each one-way bit after it is set. A design that treats any of them as plain storage would let software undo a lock.
- **Frozen fields.** It writes all-ones and all-zeros patterns under the clock lock. A wrong freeze mask would either let a frozen bit change or wrongly block a free one.
- **Stop request.** It checks that a set stop request can still be cleared under the watchdog lock, but not set again.
- **Wait count.** It checks the PLL-off case, where a design that ignores the PLL state would report one wait.

Random phases with periodic resets compare every register and output against a bench model. This catches gating errors such as a register answering to the wrong guard bit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NSLOT      = 5;
    localparam int ADDR_GUARD = 0;
    localparam int ADDR_SLOT0 = 1;
    localparam int ADDR_MODE  = 6;
    localparam logic [7:0] MODE_RST = 8'h03;

    // sticky and plain bits of the mode register, bit 0 at the right
    typedef struct packed {
        logic nmi_on;
        logic wdt_lock;
        logic clk_lock;
        logic rsv;
        logic fast_sfr;
    } mode_t;

    // bits held while the clock lock is set, per slot
    function automatic logic [7:0] frz_mask(input int idx);
        case (idx)
            0:       return 8'hA4;
            1:       return 8'h03;
            2:       return 8'h01;
            3:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // implemented bits per slot
    function automatic logic [7:0] impl_mask(input int idx);
        return (idx == 4) ? 8'h03 : 8'hFF;
    endfunction

    // slot whose bit 0 is the stop request
    function automatic logic stop_slot(input int idx);
        return idx == 1;
    endfunction

endpackage

// File: rtl/clkcfg_guard.sv
module clkcfg_guard #(
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] guard_q
);
    logic [GW-1:0] guard_d;

    always_comb begin
        guard_d = guard_q;
        if (wr_hit) guard_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) guard_q <= '0;
        else        guard_q <= guard_d;
    end
endmodule

// File: rtl/clkcfg_mode.sv
module clkcfg_mode
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [4:0] wdata,
    output mode_t      mode_q
);
    mode_t mode_d;
    mode_t wr_v;

    always_comb begin
        wr_v   = mode_t'(wdata);
        mode_d = mode_q;
        if (wr_hit) begin
            mode_d.fast_sfr = wr_v.fast_sfr;
            mode_d.rsv      = wr_v.rsv;
            mode_d.clk_lock = mode_q.clk_lock | wr_v.clk_lock;
            mode_d.wdt_lock = mode_q.wdt_lock | wr_v.wdt_lock;
            mode_d.nmi_on   = mode_q.nmi_on   | wr_v.nmi_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= mode_t'(MODE_RST[4:0]);
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/clkcfg_ctlreg.sv
module clkcfg_ctlreg #(
    parameter int          DW         = 8,
    parameter logic [DW-1:0] FRZ      = '0,
    parameter logic [DW-1:0] IMPL     = '1,
    parameter bit          STOP_GUARD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    input  logic          clk_lock,
    input  logic          wdt_lock,
    output logic [DW-1:0] val_q
);
    logic [DW-1:0] val_d;
    logic [DW-1:0] frz;
    logic [DW-1:0] stop_m;
    logic [DW-1:0] merged;

    always_comb begin
        frz    = clk_lock ? FRZ : '0;
        stop_m = (STOP_GUARD && wdt_lock)
               ? {{(DW-1){1'b0}}, ~frz[0]} : '0;
        merged = (val_q & frz) | (wdata & ~frz);
        merged = (merged & ~stop_m) | (val_q & wdata & stop_m);
        val_d  = val_q;
        if (wr_hit) val_d = merged & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
    import clkcfg_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] ctl0_o,
    output logic [DW-1:0] ctl1_o,
    output logic [DW-1:0] ctl2_o,
    output logic [DW-1:0] pll_o,
    output logic [1:0]    psel_o,
    output logic [1:0]    sfr_wait_o,
    output logic          wdt_src_onchip_o,
    output logic          onchip_osc_run_o,
    output logic          nmi_pin_o,
    output logic          clk_locked_o
);
    localparam int MW = $bits(mode_t);

    logic [GW-1:0] guard_q;
    mode_t         mode_q;
    logic [DW-1:0] slot_q [NSLOT];

    clkcfg_guard #(.GW(GW)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (bus_we && bus_addr == AW'(ADDR_GUARD)),
        .wdata   (bus_wdata[GW-1:0]),
        .guard_q (guard_q)
    );

    clkcfg_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_we && bus_addr == AW'(ADDR_MODE) && guard_q[1]),
        .wdata  (bus_wdata[MW-1:0]),
        .mode_q (mode_q)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        clkcfg_ctlreg #(
            .DW         (DW),
            .FRZ        (DW'(frz_mask(i))),
            .IMPL       (DW'(impl_mask(i))),
            .STOP_GUARD (stop_slot(i))
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (bus_we && bus_addr == AW'(ADDR_SLOT0 + i) && guard_q[0]),
            .wdata    (bus_wdata),
            .clk_lock (mode_q.clk_lock),
            .wdt_lock (mode_q.wdt_lock),
            .val_q    (slot_q[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_GUARD))
            bus_rdata = {{(DW-GW){1'b0}}, guard_q};
        else if (bus_addr == AW'(ADDR_MODE))
            bus_rdata = {{(DW-MW){1'b0}}, mode_q};
        else begin
            for (int k = 0; k < NSLOT; k++)
                if (bus_addr == AW'(ADDR_SLOT0 + k)) bus_rdata = slot_q[k];
        end
    end

    assign ctl0_o           = slot_q[0];
    assign ctl1_o           = slot_q[1];
    assign ctl2_o           = slot_q[2];
    assign pll_o            = slot_q[3];
    assign psel_o           = slot_q[4][1:0];
    assign sfr_wait_o       = (slot_q[3][7] && mode_q.fast_sfr) ? 2'd1 : 2'd2;
    assign wdt_src_onchip_o = mode_q.wdt_lock;
    assign onchip_osc_run_o = mode_q.wdt_lock | slot_q[2][1];
    assign nmi_pin_o        = mode_q.nmi_on;
    assign clk_locked_o     = mode_q.clk_lock;

endmodule

// File: rtl/clkcfg_bank_chk.sv
module clkcfg_bank_chk #(
    parameter int AW = 3,
    parameter int DW = 8,
    parameter int GW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_rdata,
    input logic [GW-1:0] guard_q,
    input logic [DW-1:0] ctl1_o,
    input logic [DW-1:0] pll_o,
    input logic [1:0]    sfr_wait_o,
    input logic          wdt_src_onchip_o,
    input logic          nmi_pin_o,
    input logic          clk_locked_o
);
    logic pll_wr_open;
    assign pll_wr_open = bus_we && bus_addr == AW'(4) && guard_q[0];

    a_r2_pll_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_wr_open |=> $stable(pll_o));

    a_r3_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == AW'(0)) |=> $stable(guard_q));

    a_r4_clk_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        clk_locked_o |=> clk_locked_o);

    a_r5_pll_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        clk_locked_o |=> $stable(pll_o));

    a_r6_wdt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_src_onchip_o |=> wdt_src_onchip_o);

    a_r7_no_stop_set: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_src_onchip_o |=> !$rose(ctl1_o[0]));

    a_r8_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pin_o |=> nmi_pin_o);

    a_r9_wait_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_o[7] |-> sfr_wait_o == 2'd2);

    a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == AW'(7) |-> bus_rdata == '0);
endmodule

bind clkcfg_bank clkcfg_bank_chk #(.AW(AW), .DW(DW), .GW(GW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_addr         (bus_addr),
    .bus_we           (bus_we),
    .bus_rdata        (bus_rdata),
    .guard_q          (guard_q),
    .ctl1_o           (ctl1_o),
    .pll_o            (pll_o),
    .sfr_wait_o       (sfr_wait_o),
    .wdt_src_onchip_o (wdt_src_onchip_o),
    .nmi_pin_o        (nmi_pin_o),
    .clk_locked_o     (clk_locked_o)
);

// File: tb/clkcfg_bank_bench.sv
module clkcfg_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata, ctl0_o, ctl1_o, ctl2_o, pll_o;
    logic [1:0] psel_o, sfr_wait_o;
    logic       wdt_src_onchip_o, onchip_osc_run_o, nmi_pin_o, clk_locked_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkcfg_bank u_clkcfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ctl0_o(ctl0_o), .ctl1_o(ctl1_o),
        .ctl2_o(ctl2_o), .pll_o(pll_o), .psel_o(psel_o), .sfr_wait_o(sfr_wait_o),
        .wdt_src_onchip_o(wdt_src_onchip_o), .onchip_osc_run_o(onchip_osc_run_o),
        .nmi_pin_o(nmi_pin_o), .clk_locked_o(clk_locked_o)
    );

    // reference model, built from the requirements
    logic [7:0] m_reg [8];

    function automatic logic [7:0] frz_of(input int a);
        case (a)
            1: return 8'hA4;
            2: return 8'h03;
            3: return 8'h01;
            4: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_reg[6] = 8'h03;
    endfunction

    function automatic void m_write(input int a, input logic [7:0] d);
        logic [7:0] f, nv, o;
        if (a == 0) m_reg[0] = d & 8'h03;
        else if (a >= 1 && a <= 5) begin
            if (m_reg[0][0]) begin
                o  = m_reg[a];
                f  = m_reg[6][2] ? frz_of(a) : 8'h00;
                nv = (o & f) | (d & ~f);
                if (a == 2 && m_reg[6][3] && !f[0]) nv[0] = o[0] & d[0];
                if (a == 5) nv = nv & 8'h03;
                m_reg[a] = nv;
            end
        end else if (a == 6) begin
            if (m_reg[0][1]) begin
                o = m_reg[6];
                m_reg[6] = {3'b000, o[4] | d[4], o[3] | d[3], o[2] | d[2], d[1], d[0]};
            end
        end
    endfunction

    function automatic logic [1:0] exp_wait();
        return (m_reg[4][7] && m_reg[6][0]) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd_chk(input string req, input int a);
        bus_addr = 3'(a);
        #1;
        chk(req, $sformatf("read addr %0d", a), int'(bus_rdata), int'(m_reg[a]));
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) rd_chk(req, a);
        chk("R11", "ctl0_o", int'(ctl0_o), int'(m_reg[1]));
        chk("R11", "ctl1_o", int'(ctl1_o), int'(m_reg[2]));
        chk("R11", "ctl2_o", int'(ctl2_o), int'(m_reg[3]));
        chk("R11", "pll_o", int'(pll_o), int'(m_reg[4]));
        chk("R11", "psel_o", int'(psel_o), int'(m_reg[5][1:0]));
        chk("R9", "sfr_wait_o", int'(sfr_wait_o), int'(exp_wait()));
        chk("R6", "wdt_src_onchip_o", int'(wdt_src_onchip_o), int'(m_reg[6][3]));
        chk("R6", "onchip_osc_run_o", int'(onchip_osc_run_o), int'(m_reg[6][3] | m_reg[3][1]));
        chk("R8", "nmi_pin_o", int'(nmi_pin_o), int'(m_reg[6][4]));
        chk("R4", "clk_locked_o", int'(clk_locked_o), int'(m_reg[6][2]));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1;
                total++; bad++;
                $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        do_reset();
        check_all("R1");

        // R2: closed guard blocks clock and mode writes
        wr(4, 8'h80); wr(1, 8'hFF); wr(6, 8'h1C);
        check_all("R2");
        chk("R2", "pll blocked", int'(pll_o), 0);

        // R3: guard bits persist; upper guard bits read 0 (R10)
        wr(0, 8'hFF);
        chk("R10", "guard upper", int'(u_read(0)), 3);
        repeat (3) @(negedge clk);
        chk("R3", "guard held", int'(u_read(0)), 3);

        // R9: PLL off gives 2, PLL on with fast bit gives 1
        wr(6, 8'h01);
        chk("R9", "pll off wait", int'(sfr_wait_o), 2);
        wr(4, 8'h80);
        chk("R9", "pll on wait", int'(sfr_wait_o), 1);
        wr(6, 8'h00);
        chk("R9", "slow bit wait", int'(sfr_wait_o), 2);

        // R10: unused bits
        wr(5, 8'hFF);
        chk("R10", "psel upper", int'(u_read(5)), 3);
        wr(6, 8'hE0);
        chk("R10", "mode upper", int'(u_read(6)), 0);

        // R7: stop bit set then cleared before lock, not set after lock
        wr(2, 8'h01);
        chk("R7", "stop set pre lock", int'(ctl1_o), 1);
        wr(6, 8'h08);
        chk("R6", "wdt src", int'(wdt_src_onchip_o), 1);
        chk("R6", "osc run", int'(onchip_osc_run_o), 1);
        wr(2, 8'h00);
        chk("R7", "stop cleared", int'(ctl1_o), 0);
        wr(2, 8'h01);
        chk("R7", "stop not set", int'(ctl1_o), 0);
        wr(6, 8'h00);
        chk("R6", "wdt lock sticky", int'(wdt_src_onchip_o), 1);

        // R4 / R5: clock lock freezes listed bits only
        wr(1, 8'h00); wr(3, 8'h00);
        wr(6, 8'h04);
        wr(6, 8'h00);
        chk("R4", "clk lock sticky", int'(clk_locked_o), 1);
        wr(1, 8'hFF);
        chk("R5", "ctl0 free bits", int'(ctl0_o), 8'h5B);
        wr(2, 8'hFE);
        chk("R5", "ctl1 frozen", int'(ctl1_o), 8'hFC);
        wr(3, 8'hFF);
        chk("R5", "ctl2 frozen bit0", int'(ctl2_o), 8'hFE);
        wr(4, 8'h00);
        chk("R5", "pll frozen", int'(pll_o), 8'h80);

        // R8: NMI bit sticky
        wr(6, 8'h10); wr(6, 8'h00);
        chk("R8", "nmi sticky", int'(nmi_pin_o), 1);

        // R11: reads unaffected by closed guard
        wr(0, 8'h00);
        check_all("R11");

        do_reset();
        check_all("R1");

        // random phases against the model
        for (int it = 0; it < 1200; it++) begin
            int a;
            logic [7:0] d;
            if (it % 60 == 0) do_reset();
            a = int'($urandom % 8);
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin a = 0; d = 8'($urandom % 4); end
            if (a == 6 && ($urandom % 3 != 0)) d = d & 8'hE3;
            wr(a, d);
            check_all("R11");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] u_read(input int a);
        return m_reg[a] ^ m_reg[a] ^ read_now(a);
    endfunction

    function automatic logic [7:0] read_now(input int a);
        case (a)
            0: return {6'b0, m_reg_dut_guard()};
            default: return dut_read(a);
        endcase
    endfunction

    function automatic logic [1:0] m_reg_dut_guard();
        return dut_read(0) & 8'h03 ? dut_read(0)[1:0] : 2'b00;
    endfunction

    function automatic logic [7:0] dut_read(input int a);
        return (int'(bus_addr) == a) ? bus_rdata : bus_rdata_at(a);
    endfunction

    function automatic logic [7:0] bus_rdata_at(input int a);
        case (a)
            1: return ctl0_o;
            2: return ctl1_o;
            3: return ctl2_o;
            4: return pll_o;
            5: return {6'b0, psel_o};
            6: return {3'b0, nmi_pin_o, wdt_src_onchip_o, clk_locked_o, 2'b00} | 8'(bus_addr == 3'd6 ? bus_rdata : 8'h00);
            default: return 8'h00;
        endcase
    endfunction
endmodule